// File: doc/BRIEF.md
# Frame-Synchronous Alarm Interrupt Controller

This block gathers alarm indications from eight line channels and turns them into one active-high interrupt line plus a small set of registers for a host processor. Each channel carries two kinds of alarm. Level alarms are sampled once per frame, when a one-cycle frame strobe arrives. Pulse alarms, such as events and overflows, are caught on the cycle they occur. A level alarm requests service each time its sampled value changes, in either direction. A pulse alarm requests service every time it fires.

Per channel, the host sees three registers: a source register that records which alarms are pending, a status register that holds the last frame snapshot, and an enable register that masks each alarm from the interrupt line. Reading a channel's status register clears that channel's pending sources. A global control bit freezes the snapshot so that the host can read it without contention. Pulses that arrive while the snapshot is frozen are held back and then merged into the source register when updates resume, so none of them is lost.

The register port is plain and synchronous. A read is issued with `rd_en` and `addr`, and the data appears on `rdata` one cycle later. A write takes effect at the clock edge on which `wr_en` is high.

Top module: `alm_intc`

## Requirements
- R1: When updates are enabled, a frame strobe loads each channel's level inputs into status bits [3:0]. Without a frame strobe, the status registers hold their value.
- R2: At a sampling strobe, every level alarm whose new value differs from the stored snapshot sets its source bit (bits [3:0]). A change from 0 to 1 and a change from 1 to 0 both do this. An unchanged level sets nothing.
- R3: When updates are enabled, a pulse on event input k of a channel sets source bit 4+k of that channel on the next clock edge. No frame strobe is needed.
- R4: Status bits [7:4] show which event inputs pulsed during the frame interval that the last sampling strobe closed. A pulse on the strobe cycle itself counts toward that interval.
- R5: While control bit 0 (update-disable) is 1, the following all stay unchanged: the status registers, the level-change source bits, and the event source bits.
- R6: Event pulses that arrive while update-disable is 1 are held. They appear in the source register once update-disable returns to 0.
- R7: Reading a channel's status register clears all eight source bits of that channel. A source bit that is newly set on the same cycle remains set.
- R8: Reading a source register returns the pending bits and clears nothing.
- R9: `irq` is 1 exactly when some channel has a source bit set whose enable bit is also set. An alarm whose enable bit is 0 never drives `irq`.
- R10: After reset, all source, status and enable bits and the control bit are 0, and `irq` is 0.
- R11: Address map. A channel register sits at address {1'b0, ch[2:0], sel[1:0]}, where sel is 0 for source, 1 for status and 2 for enable. The control register is at 0x20, with update-disable in bit 0. sel = 3 reads 0. Read data appears on `rdata` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle frame marker; level alarms are sampled on it |
| lvl_in | input | 32 | Level alarms, 4 per channel, channel c at [4c+3:4c] |
| evt_in | input | 32 | Pulse alarms, 4 per channel, channel c at [4c+3:4c] |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after rd_en |
| irq | output | 1 | Active-high interrupt request |

## Verification
Wrong snapshot state appears at the ports in two places: in the source bits that the next frame strobe sets, and in a status read, which returns it one cycle after the request. A lost or stuck pending bit shows on `irq` within one cycle, provided the alarm's enable is set. A held pulse that is dropped, or merged too early, shows in the first source read after update-disable changes. The table-driven sequence walks level changes in both directions, including an unchanged level. The directed tests cover masking, the freeze window and the clear-on-read rule.

// File: rtl/alm_intc_pkg.sv
package alm_intc_pkg;

    localparam int DEF_NCH   = 8;
    localparam int DEF_NLVL  = 4;
    localparam int DEF_NEVT  = 4;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_EN   = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     chan_hit;
        logic     ctrl_hit;
        reg_sel_e sel;
    } dec_t;

    function automatic logic any_set(input logic [31:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/alm_chan.sv
module alm_chan #(
    parameter int NLVL = alm_intc_pkg::DEF_NLVL,
    parameter int NEVT = alm_intc_pkg::DEF_NEVT,
    localparam int NA  = NLVL + NEVT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_stb,
    input  logic            upd_dis,
    input  logic [NLVL-1:0] lvl_in,
    input  logic [NEVT-1:0] evt_in,
    input  logic            en_we,
    input  logic [NA-1:0]   en_wd,
    input  logic            clr_src,
    output logic [NA-1:0]   src,
    output logic [NA-1:0]   en,
    output logic [NA-1:0]   stat,
    output logic            irq_ch
);
    logic [NLVL-1:0] snap_lvl;
    logic [NEVT-1:0] snap_evt;
    logic [NEVT-1:0] pend, pend_n;
    logic [NEVT-1:0] acc, acc_n;
    logic            samp;
    logic [NLVL-1:0] set_lvl;
    logic [NEVT-1:0] set_evt;
    logic [NA-1:0]   set_all;

    always_comb begin
        samp    = frame_stb & ~upd_dis;
        pend_n  = pend | evt_in;
        acc_n   = acc | evt_in;
        set_lvl = samp ? (lvl_in ^ snap_lvl) : '0;
        set_evt = upd_dis ? '0 : pend_n;
        set_all = {set_evt, set_lvl};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_lvl <= '0;
            snap_evt <= '0;
            pend     <= '0;
            acc      <= '0;
            src      <= '0;
            en       <= '0;
        end else begin
            if (en_we)
                en <= en_wd;
            if (samp) begin
                snap_lvl <= lvl_in;
                snap_evt <= acc_n;
                acc      <= '0;
            end else begin
                acc      <= acc_n;
            end
            pend <= upd_dis ? pend_n : '0;
            src  <= (src & ~{NA{clr_src}}) | set_all;
        end
    end

    assign stat   = {snap_evt, snap_lvl};
    assign irq_ch = |(src & en);

endmodule

// File: rtl/alm_regs.sv
module alm_regs
    import alm_intc_pkg::*;
#(
    parameter int NCH = DEF_NCH,
    parameter int NA  = DEF_NLVL + DEF_NEVT,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [NA-1:0]     wdata,
    input  logic [NCH*NA-1:0] src_all,
    input  logic [NCH*NA-1:0] en_all,
    input  logic [NCH*NA-1:0] stat_all,
    output logic [NA-1:0]     rdata,
    output logic              upd_dis,
    output logic [NCH-1:0]    en_we,
    output logic [NCH-1:0]    clr_src
);
    localparam logic [AW-1:0] CTRL_ADDR = AW'(1) << (AW - 1);

    dec_t           dec;
    logic [CHW-1:0] ch;
    logic [NA-1:0]  rd_mux;

    always_comb begin
        ch           = addr[CHW+1:2];
        dec.chan_hit = ~addr[AW-1];
        dec.ctrl_hit = (addr == CTRL_ADDR);
        dec.sel      = reg_sel_e'(addr[1:0]);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_strobe
        assign en_we[c]   = wr_en & dec.chan_hit & (ch == CHW'(c)) & (dec.sel == SEL_EN);
        assign clr_src[c] = rd_en & dec.chan_hit & (ch == CHW'(c)) & (dec.sel == SEL_STAT);
    end

    always_comb begin
        rd_mux = '0;
        if (dec.ctrl_hit) begin
            rd_mux[0] = upd_dis;
        end else if (dec.chan_hit) begin
            unique case (dec.sel)
                SEL_SRC:  rd_mux = src_all[ch*NA +: NA];
                SEL_STAT: rd_mux = stat_all[ch*NA +: NA];
                SEL_EN:   rd_mux = en_all[ch*NA +: NA];
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            upd_dis <= 1'b0;
        end else begin
            if (rd_en)
                rdata <= rd_mux;
            if (wr_en && dec.ctrl_hit)
                upd_dis <= wdata[0];
        end
    end

endmodule

// File: rtl/alm_irq_or.sv
module alm_irq_or #(
    parameter int N = alm_intc_pkg::DEF_NCH
) (
    input  logic [N-1:0] req,
    output logic         any
);
    localparam int W = (N < 2) ? 2 : N;
    logic [W-1:0] pad;

    assign pad = W'(req);

    if (N == 1) begin : g_one
        assign any = pad[0];
    end else begin : g_many
        logic [N-1:0] chain;
        assign chain[0] = pad[0];
        for (genvar i = 1; i < N; i++) begin : g_or
            assign chain[i] = chain[i-1] | pad[i];
        end
        assign any = chain[N-1];
    end

endmodule

// File: rtl/alm_intc.sv
module alm_intc
    import alm_intc_pkg::*;
#(
    parameter int NCH  = DEF_NCH,
    parameter int NLVL = DEF_NLVL,
    parameter int NEVT = DEF_NEVT,
    localparam int NA  = NLVL + NEVT,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_stb,
    input  logic [NCH*NLVL-1:0] lvl_in,
    input  logic [NCH*NEVT-1:0] evt_in,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [AW-1:0]       addr,
    input  logic [NA-1:0]       wdata,
    output logic [NA-1:0]       rdata,
    output logic                irq
);
    logic [NCH*NA-1:0] src_all;
    logic [NCH*NA-1:0] en_all;
    logic [NCH*NA-1:0] stat_all;
    logic [NCH-1:0]    en_we;
    logic [NCH-1:0]    clr_src;
    logic [NCH-1:0]    irq_ch;
    logic              upd_dis;

    alm_regs #(.NCH(NCH), .NA(NA)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .src_all  (src_all),
        .en_all   (en_all),
        .stat_all (stat_all),
        .rdata    (rdata),
        .upd_dis  (upd_dis),
        .en_we    (en_we),
        .clr_src  (clr_src)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        alm_chan #(.NLVL(NLVL), .NEVT(NEVT)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .frame_stb (frame_stb),
            .upd_dis   (upd_dis),
            .lvl_in    (lvl_in[c*NLVL +: NLVL]),
            .evt_in    (evt_in[c*NEVT +: NEVT]),
            .en_we     (en_we[c]),
            .en_wd     (wdata),
            .clr_src   (clr_src[c]),
            .src       (src_all[c*NA +: NA]),
            .en        (en_all[c*NA +: NA]),
            .stat      (stat_all[c*NA +: NA]),
            .irq_ch    (irq_ch[c])
        );
    end

    alm_irq_or #(.N(NCH)) u_or (
        .req (irq_ch),
        .any (irq)
    );

endmodule

// File: rtl/alm_intc_chk.sv
module alm_intc_chk #(
    parameter int NCH  = 8,
    parameter int NLVL = 4,
    parameter int NEVT = 4,
    localparam int NA  = NLVL + NEVT,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + 3
) (
    input logic                clk,
    input logic                rst,
    input logic                frame_stb,
    input logic [NCH*NEVT-1:0] evt_in,
    input logic                rd_en,
    input logic [AW-1:0]       addr,
    input logic                irq,
    input logic                upd_dis,
    input logic [NCH*NA-1:0]   src_all,
    input logic [NCH*NA-1:0]   en_all,
    input logic [NCH*NA-1:0]   stat_all
);
    logic [NCH*NEVT-1:0] src_evt;
    for (genvar c = 0; c < NCH; c++) begin : g_map
        assign src_evt[c*NEVT +: NEVT] = src_all[c*NA + NLVL +: NEVT];
    end

    // R10
    rst_irq_chk: assert property (@(posedge clk) rst |=> !irq);

    // R9
    mask_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (en_all == '0) |-> !irq);

    // R5
    freeze_stat_chk: assert property (@(posedge clk) disable iff (rst)
        upd_dis |=> $stable(stat_all));

    // R1
    hold_stat_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(stat_all));

    // R3
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_dis && (evt_in != '0)) |=> ((src_evt & $past(evt_in)) == $past(evt_in)));

    for (genvar c = 0; c < NCH; c++) begin : g_clr
        // R7
        rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_en && upd_dis && addr == {1'b0, CHW'(c), 2'd1})
            |=> (src_all[c*NA +: NA] == '0));
    end

endmodule

bind alm_intc alm_intc_chk #(.NCH(NCH), .NLVL(NLVL), .NEVT(NEVT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .evt_in    (evt_in),
    .rd_en     (rd_en),
    .addr      (addr),
    .irq       (irq),
    .upd_dis   (upd_dis),
    .src_all   (src_all),
    .en_all    (en_all),
    .stat_all  (stat_all)
);

// File: tb/sim_alm_intc.sv
module sim_alm_intc;
    localparam int NCH = 8;
    localparam int NL  = 4;
    localparam int NE  = 4;

    typedef struct packed {
        logic [2:0] ch;
        logic [3:0] lvl;
        logic [7:0] exp_src;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{ch: 3'd2, lvl: 4'b0101, exp_src: 8'h05},
        '{ch: 3'd2, lvl: 4'b0111, exp_src: 8'h02},
        '{ch: 3'd2, lvl: 4'b0011, exp_src: 8'h04},
        '{ch: 3'd2, lvl: 4'b0011, exp_src: 8'h00},
        '{ch: 3'd2, lvl: 4'b0000, exp_src: 8'h03},
        '{ch: 3'd7, lvl: 4'b1000, exp_src: 8'h08}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_stb = 1'b0;
    logic [NCH*NL-1:0] lvl_in = '0;
    logic [NCH*NE-1:0] evt_in = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [5:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          irq;

    int total = 0;
    int bad = 0;
    logic [7:0] v;

    always #5 clk = ~clk;

    alm_intc u0 (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .lvl_in(lvl_in),
        .evt_in(evt_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [5:0] ra(input int ch, input int sel);
        return {1'b0, 3'(ch), 2'(sel)};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
        d     = rdata;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame();
        @(negedge clk);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic pulse(input int bitn);
        @(negedge clk);
        evt_in[bitn] = 1'b1;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        check("R10 irq", {7'd0, irq}, 8'h00);
        rd(ra(2, 0), v); check("R10 src", v, 8'h00);
        rd(ra(2, 1), v); check("R10 stat", v, 8'h00);
        rd(ra(2, 2), v); check("R10 en", v, 8'h00);
        rd(6'h20, v);    check("R10 ctrl", v, 8'h00);

        // R1 R2 R7 R8 table walk
        for (int i = 0; i < NV; i++) begin
            lvl_in[VECS[i].ch*NL +: NL] = VECS[i].lvl;
            frame();
            rd(ra(VECS[i].ch, 0), v); check("R2 src after frame", v, VECS[i].exp_src);
            rd(ra(VECS[i].ch, 0), v); check("R8 src read no clear", v, VECS[i].exp_src);
            rd(ra(VECS[i].ch, 1), v); check("R1 stat snapshot", v, {4'h0, VECS[i].lvl});
            rd(ra(VECS[i].ch, 0), v); check("R7 src cleared by stat read", v, 8'h00);
        end

        // R11 reserved slot and enable readback
        rd(ra(2, 3), v); check("R11 reserved", v, 8'h00);
        wr(ra(2, 2), 8'h11);
        rd(ra(2, 2), v); check("R11 en readback", v, 8'h11);

        // R9 enabled level alarm drives irq
        lvl_in[2*NL +: NL] = 4'b0001;
        frame();
        check("R9 irq enabled", {7'd0, irq}, 8'h01);
        rd(ra(2, 1), v); check("R1 stat", v, 8'h01);
        @(negedge clk);
        check("R7 irq drops after stat read", {7'd0, irq}, 8'h00);

        // R9 masked alarm sets source but not irq
        lvl_in[2*NL +: NL] = 4'b0011;
        frame();
        check("R9 masked no irq", {7'd0, irq}, 8'h00);
        rd(ra(2, 0), v); check("R2 masked src", v, 8'h02);
        rd(ra(2, 1), v);

        // R3 event sets source next cycle, enabled bit 4 of ch2
        pulse(2*NE + 0);
        check("R3 event irq", {7'd0, irq}, 8'h01);
        rd(ra(2, 0), v); check("R3 event src", v, 8'h10);

        // R4 event summary in status upper bits
        frame();
        rd(ra(2, 1), v); check("R4 stat evt", v, 8'h13);
        frame();
        rd(ra(2, 1), v); check("R4 stat evt cleared", v, 8'h03);

        // R5 R6 freeze window
        wr(6'h20, 8'h01);
        rd(6'h20, v); check("R11 ctrl", v, 8'h01);
        lvl_in[5*NL +: NL] = 4'b1111;
        frame();
        pulse(5*NE + 2);
        rd(ra(5, 0), v); check("R5 src frozen", v, 8'h00);
        rd(ra(5, 1), v); check("R5 stat frozen", v, 8'h00);
        wr(6'h20, 8'h00);
        rd(ra(5, 0), v); check("R6 held event merged", v, 8'h40);
        frame();
        rd(ra(5, 0), v); check("R2 after thaw", v, 8'h4F);
        rd(ra(5, 1), v); check("R4 stat after thaw", v, 8'h4F);

        // R7 set in same cycle as clear survives
        @(negedge clk);
        rd_en = 1'b1; addr = ra(5, 1); evt_in[5*NE + 1] = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; evt_in = '0;
        rd(ra(5, 0), v); check("R7 set wins over clear", v, 8'h20);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule